// File: doc/BRIEF.md
# Power-Fail Gated Memory Bus Controller

This block sits between an asynchronous SRAM-style host bus and two storage targets: an external byte-wide RAM and an internal file of 16 clock registers. It samples the active-low host strobes (chip-enable, output-enable, write-enable) on the system clock. From them it decodes deselect, idle, read and write. It then drives the RAM's own chip-enable, output-enable and write-enable, and controls the tri-state enable of the host data bus.

Addresses in the topmost 16 locations of the host address space go to the internal clock register file, and the external RAM stays deselected for them. A power-fail flag passes through a synchronizer and then locks out every access. The lock engages and releases only while the host chip-enable is high, so an access in flight when power starts failing runs to its end. After power returns, no new access gets through until the host has deselected once.

All decoded outputs follow the host strobes with a latency of one clock.

Top module: `pfgate_top`

## Requirements
- R1: While reset is asserted and right after it, ramCeN, ramOeN and ramWeN are all 1 and hostDataOe is 0. Every clock register reads back as 0x00.
- R2: With hostCeN high, the RAM enables stay inactive (1) and hostDataOe is 0, whatever hostOeN and hostWeN are.
- R3: A read to a RAM address drives ramCeN=0, ramOeN=0 and hostDataOe=1, and hostRdData equals ramRdData. A read is hostCeN=0, hostWeN=1 and hostOeN=0. The response comes one clock after the strobes are sampled.
- R4: hostCeN=0 with hostWeN=1 and hostOeN=1 selects the RAM (ramCeN=0), keeps ramOeN=1, and leaves hostDataOe at 0.
- R5: hostCeN=0 with hostWeN=0 is a write: ramWeN=0 for RAM addresses, ramOeN=1 and hostDataOe=0, even when hostOeN is also low.
- R6: A write starts only when both hostCeN and hostWeN are low. With only one of them low, ramWeN stays 1 and no clock register changes.
- R7: The address region is set by the upper address bits. When they are all ones (the top 16 locations), ramCeN stays 1. A write stores hostWrData into the register picked by the low 4 address bits, and a read returns that register on hostRdData with hostDataOe=1. The address just below that region still goes to the RAM.
- R8: Once lockout is in effect, an access drives no RAM enable and does not set hostDataOe. A write during lockout leaves the clock registers unchanged.
- R9: If powerFail rises while hostCeN is held low, the access in progress keeps its RAM enables and bus drive until hostCeN goes high.
- R10: After powerFail falls, the lockout stays in effect until hostCeN has been sampled high. An access held low across the release stays blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerFail | input | 1 | Asynchronous supply-failing flag, active high |
| hostCeN | input | 1 | Host chip-enable, active low |
| hostOeN | input | 1 | Host output-enable, active low |
| hostWeN | input | 1 | Host write-enable, active low |
| hostAddr | input | ADDR_W | Host address |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Read data toward the host bus |
| hostDataOe | output | 1 | Tri-state enable of the host data bus, active high |
| ramCeN | output | 1 | External RAM chip-enable, active low |
| ramOeN | output | 1 | External RAM output-enable, active low |
| ramWeN | output | 1 | External RAM write-enable, active low |
| ramRdData | input | DATA_W | Data returned by the external RAM |

## Verification
The hardest condition to reach is the rule that the lockout only moves while the host is deselected. It must be shown in both directions: a read that began before the power-fail flag rose has to survive it, and a host that holds chip-enable low across the power return has to stay blocked. The stimulus reaches these states with long held strobes. It raises and drops powerFail in the middle of an access, waits well past the synchronizer depth, and only then toggles chip-enable. A write attempted during lockout is checked afterwards by reading the targeted clock register once access is restored.

// File: rtl/pfgate_pkg.sv
package pfgate_pkg;

  typedef enum logic [2:0] {
    MODE_DESELECT,
    MODE_IDLE,
    MODE_READ,
    MODE_WRITE,
    MODE_LOCKED
  } busMode_t;

  typedef struct packed {
    logic ramSel;
    logic ramRead;
    logic ramWrite;
    logic regWrite;
    logic busDrive;
  } strobe_t;

endpackage

// File: rtl/pfgate_ctrl.sv
module pfgate_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                powerFail,
  input  logic                hostCeN,
  input  logic                hostOeN,
  input  logic                hostWeN,
  input  logic                regHit,
  output pfgate_pkg::strobe_t strobes
);
  import pfgate_pkg::*;

  logic [SYNC_STAGES-1:0] syncQ;
  logic pfSync;
  logic ceQ, oeQ, weQ;
  logic lockedQ;
  busMode_t mode;

  // power-fail synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], powerFail};
  end
  assign pfSync = syncQ[SYNC_STAGES-1];

  // host strobe sampling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ <= 1'b1;
      oeQ <= 1'b1;
      weQ <= 1'b1;
    end else begin
      ceQ <= hostCeN;
      oeQ <= hostOeN;
      weQ <= hostWeN;
    end
  end

  // lockout moves only while the host is deselected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    lockedQ <= 1'b1;
    else if (ceQ) lockedQ <= pfSync;
  end

  always_comb begin
    if (ceQ)          mode = MODE_DESELECT;
    else if (lockedQ) mode = MODE_LOCKED;
    else if (!weQ)    mode = MODE_WRITE;
    else if (!oeQ)    mode = MODE_READ;
    else              mode = MODE_IDLE;
  end

  always_comb begin
    strobes          = '0;
    strobes.ramSel   = (mode == MODE_READ || mode == MODE_WRITE || mode == MODE_IDLE) && !regHit;
    strobes.ramRead  = (mode == MODE_READ) && !regHit;
    strobes.ramWrite = (mode == MODE_WRITE) && !regHit;
    strobes.regWrite = (mode == MODE_WRITE) && regHit;
    strobes.busDrive = (mode == MODE_READ);
  end

  a_r8_lock_quiet: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ |-> !strobes.ramSel && !strobes.busDrive && !strobes.regWrite);

  a_r10_lock_moves_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockedQ) |-> $past(ceQ));

  a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    !weQ |-> !strobes.busDrive);

  a_r7_top_no_ram: assert property (@(posedge clk) disable iff (!rstN)
    regHit |-> !strobes.ramSel);

  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ceQ |-> (strobes == '0));

endmodule

// File: rtl/pfgate_dp.sv
module pfgate_dp #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int REG_CNT = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostWrData,
  input  logic [DATA_W-1:0]   ramRdData,
  input  pfgate_pkg::strobe_t strobes,
  output logic                regHit,
  output logic [DATA_W-1:0]   hostRdData
);
  localparam int REG_AW = $clog2(REG_CNT);
  localparam int HI_W   = ADDR_W - REG_AW;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] regQ [REG_CNT];
  logic [REG_AW-1:0] regIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      addrQ <= hostAddr;
      dataQ <= hostWrData;
    end
  end

  assign regIdx = addrQ[REG_AW-1:0];
  assign regHit = (addrQ[ADDR_W-1:REG_AW] == {HI_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) regQ[i] <= '0;
    end else if (strobes.regWrite) begin
      regQ[regIdx] <= dataQ;
    end
  end

  assign hostRdData = regHit ? regQ[regIdx] : ramRdData;

  for (genvar g = 0; g < REG_CNT; g++) begin : gRegChk
    localparam logic [REG_AW-1:0] IDX = REG_AW'(g);
    a_r8_reg_write_only: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(regQ[g]) |-> $past(strobes.regWrite) && ($past(regIdx) == IDX));
  end

endmodule

// File: rtl/pfgate_top.sv
module pfgate_top #(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int REG_CNT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerFail,
  input  logic              hostCeN,
  input  logic              hostOeN,
  input  logic              hostWeN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostDataOe,
  output logic              ramCeN,
  output logic              ramOeN,
  output logic              ramWeN,
  input  logic [DATA_W-1:0] ramRdData
);
  pfgate_pkg::strobe_t strobes;
  logic regHit;

  pfgate_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .powerFail(powerFail),
    .hostCeN(hostCeN), .hostOeN(hostOeN), .hostWeN(hostWeN),
    .regHit(regHit), .strobes(strobes)
  );

  pfgate_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_CNT(REG_CNT)) uDp (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .ramRdData(ramRdData), .strobes(strobes), .regHit(regHit),
    .hostRdData(hostRdData)
  );

  assign ramCeN     = ~strobes.ramSel;
  assign ramOeN     = ~strobes.ramRead;
  assign ramWeN     = ~strobes.ramWrite;
  assign hostDataOe = strobes.busDrive;

  a_r3_drive_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe |-> !hostOeN || !$stable(hostOeN) || $past(!hostOeN));

endmodule

// File: tb/tb_pfgate_top.sv
module tb_pfgate_top;
  logic clk = 0;
  logic rstN = 0;
  logic powerFail = 0;
  logic hostCeN = 1, hostOeN = 1, hostWeN = 1;
  logic [18:0] hostAddr = '0;
  logic [7:0] hostWrData = '0, ramRdData = '0;
  logic [7:0] hostRdData;
  logic hostDataOe, ramCeN, ramOeN, ramWeN;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pfgate_top dut (
    .clk(clk), .rstN(rstN), .powerFail(powerFail),
    .hostCeN(hostCeN), .hostOeN(hostOeN), .hostWeN(hostWeN),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .hostDataOe(hostDataOe), .ramCeN(ramCeN), .ramOeN(ramOeN), .ramWeN(ramWeN),
    .ramRdData(ramRdData)
  );

  // {ce,oe,we, addr[19], wd[8], rr[8], eCe,eOe,eWe,eBus, eRd[8]}
  localparam int NV = 12;
  localparam logic [49:0] VEC [NV] = '{
    {3'b101, 19'h00000, 8'h00, 8'h00, 4'b1110, 8'h00},
    {3'b001, 19'h00123, 8'h00, 8'hA5, 4'b0011, 8'hA5},
    {3'b011, 19'h00123, 8'h00, 8'h00, 4'b0110, 8'h00},
    {3'b010, 19'h00200, 8'h11, 8'h00, 4'b0100, 8'h00},
    {3'b000, 19'h00200, 8'h22, 8'h00, 4'b0100, 8'h00},
    {3'b110, 19'h00200, 8'h33, 8'h00, 4'b1110, 8'h00},
    {3'b010, 19'h7FFF3, 8'h3C, 8'h00, 4'b1110, 8'h00},
    {3'b001, 19'h7FFF3, 8'h00, 8'h99, 4'b1111, 8'h3C},
    {3'b001, 19'h7FFF4, 8'h00, 8'h99, 4'b1111, 8'h00},
    {3'b000, 19'h7FFFF, 8'h81, 8'h00, 4'b1110, 8'h00},
    {3'b001, 19'h7FFFF, 8'h00, 8'h00, 4'b1111, 8'h81},
    {3'b001, 19'h7FFEF, 8'h00, 8'h5A, 4'b0011, 8'h5A}
  };
  string vecReq [NV];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic ce, input logic oe, input logic we,
                       input logic [18:0] a, input logic [7:0] wd, input logic [7:0] rr);
    hostCeN = ce; hostOeN = oe; hostWeN = we;
    hostAddr = a; hostWrData = wd; ramRdData = rr;
    @(posedge clk); #2;
  endtask

  task automatic checkPins(input string req, input logic eCe, input logic eOe,
                           input logic eWe, input logic eBus);
    check({req, " ramCeN"}, {7'd0, ramCeN}, {7'd0, eCe});
    check({req, " ramOeN"}, {7'd0, ramOeN}, {7'd0, eOe});
    check({req, " ramWeN"}, {7'd0, ramWeN}, {7'd0, eWe});
    check({req, " hostDataOe"}, {7'd0, hostDataOe}, {7'd0, eBus});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #2; end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    vecReq = '{"R2", "R3", "R4", "R5", "R5", "R6", "R7", "R7", "R1", "R7", "R7", "R7"};
    // R1: reset state with strobes active
    hostCeN = 0; hostOeN = 0; hostWeN = 1;
    idle(3);
    checkPins("R1 in reset", 1, 1, 1, 0);
    hostCeN = 1; hostOeN = 1;
    @(negedge clk); rstN = 1;
    idle(3);
    checkPins("R1 after reset", 1, 1, 1, 0);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      apply(v[49], v[48], v[47], v[46:28], v[27:20], v[19:12]);
      checkPins(vecReq[i], v[11], v[10], v[9], v[8]);
      if (v[8]) check({vecReq[i], " rdData"}, hostRdData, v[7:0]);
    end

    // R6: ce low first, then we joins: write only once both low
    apply(0, 1, 1, 19'h00300, 8'h00, 8'h00);
    checkPins("R6 ce only", 0, 1, 1, 0);
    apply(0, 1, 0, 19'h00300, 8'h00, 8'h00);
    checkPins("R6 both low", 0, 1, 0, 0);
    // R6: register untouched when only we low
    apply(1, 1, 0, 19'h7FFF5, 8'hEE, 8'h00);
    apply(1, 1, 1, 19'h7FFF5, 8'h00, 8'h00);
    apply(0, 0, 1, 19'h7FFF5, 8'h00, 8'h00);
    check("R6 reg untouched", hostRdData, 8'h00);

    // R9: read in progress survives power fail
    apply(0, 0, 1, 19'h00400, 8'h00, 8'h6B);
    powerFail = 1;
    idle(5);
    checkPins("R9 in flight", 0, 0, 1, 1);
    check("R9 data", hostRdData, 8'h6B);
    apply(1, 1, 1, 19'h00400, 8'h00, 8'h00);
    idle(2);
    // R8: locked access blocked
    apply(0, 0, 1, 19'h00400, 8'h00, 8'h6B);
    checkPins("R8 read blocked", 1, 1, 1, 0);
    apply(0, 1, 0, 19'h7FFF3, 8'hFF, 8'h00);
    idle(2);
    checkPins("R8 write blocked", 1, 1, 1, 0);
    // R10: release while ce held low stays blocked
    powerFail = 0;
    idle(6);
    apply(0, 0, 1, 19'h00400, 8'h00, 8'h6B);
    checkPins("R10 held low", 1, 1, 1, 0);
    apply(1, 1, 1, 19'h00400, 8'h00, 8'h00);
    idle(2);
    apply(0, 0, 1, 19'h7FFF3, 8'h00, 8'h00);
    checkPins("R10 released", 1, 1, 1, 1);
    check("R8 reg kept", hostRdData, 8'h3C);
    apply(0, 0, 1, 19'h00010, 8'h00, 8'hC3);
    checkPins("R10 ram read", 0, 0, 1, 1);
    check("R10 ram data", hostRdData, 8'hC3);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule